// File: doc/BRIEF.md
# Multi-Rail Power-Good Delay Sequencer

This block watches four digital "rail above threshold" flags, each standing for the output of an analog comparator on one supply. For every rail it drives an active-low power-good output. That output is pulled low only once its rail has stayed good for a delay chosen per rail. A single active-low system reset is held until every rail has finished its delay. It then releases after a further hold time with its own selectable code. A rail that drops at any point pulls its good output and the reset back to their active levels, and the sequence starts over once the rail returns.

A manual reset input, accepted only after a minimum hold, forces every output to its active level. When it is released, the outputs sequence out again. Four sticky flags record which rails have failed since software last preset them. All delays count one shared prescaled tick of 10 ms, so a simulation can shorten every timeout with one parameter. Delay codes arrive on plain configuration inputs.

Top module: `rail_seq_top`

## Requirements
- R1: While and just after reset, `pgN` is 4'hF, `rstOutN` is 0 and `faultFlags` is 4'h0.
- R2: A 2-bit delay code selects 10, 50, 100 or 500 ticks for codes 00, 01, 10 and 11. A power-good output falls low after its rail has been good for more than N and at most N+1 ticks, plus at most four clock cycles of input latency.
- R3: Rail k (k = 0..3) takes its delay code from `railDlyCfg[2k+1:2k]`, and the rails time out independently of each other.
- R4: When a rail drops, its `pgN` bit returns high within four clock cycles. A drop during the countdown restarts that rail's count from zero.
- R5: `rstOutN` stays low until all four `pgN` bits are low. It then rises after the post-delay selected by `postDlyCfg`, which uses the same code table as R2.
- R6: Any rail dropping drives `rstOutN` low within four clock cycles, and the full sequence repeats once the rails recover.
- R7: A high level on `mrIn` held for fewer than `MR_CYCLES` clock cycles has no effect. A level held for `MR_CYCLES` plus four cycles forces `pgN` to 4'hF and `rstOutN` to 0.
- R8: After `mrIn` falls, with all rails good, each `pgN` bit and then `rstOutN` release again after their programmed delays.
- R9: `faultFlags[k]` goes to 0 while rail k is low. A pulse on `faultSet[k]` sets the flag to 1 only if rail k is good, and a clear wins over a set. A flag at 0 stays at 0 until it is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| railOk | input | 4 | Rail above threshold flags (asynchronous) |
| mrIn | input | 1 | Manual reset request, active high (asynchronous) |
| railDlyCfg | input | 8 | Per-rail 2-bit delay codes, rail k at bits 2k+1:2k |
| postDlyCfg | input | 2 | Delay code for the reset hold after all rails are done |
| faultSet | input | 4 | Per-rail pulse that presets a fault flag to 1 |
| pgN | output | 4 | Per-rail power-good, low when the rail is good and its delay is done |
| rstOutN | output | 1 | System reset, active low |
| faultFlags | output | 4 | Sticky per-rail flags, 0 when the rail has failed |

## Verification
On every cycle the assertions check the following relations. A synchronized rail drop is followed two cycles later by a raised good bit and an asserted reset. A released reset always implies that all good bits are low. An accepted manual reset forces every output, and the fault flags follow their clear and sticky rules. Only the bench scenarios can show the length of each delay code and that each rail reads its own bit field. They also cover the restart after a glitch in mid-count, the rejection of a short manual pulse and the re-release after the manual reset, because these depend on tick counts and elapsed windows rather than on relations from one cycle to the next.

// File: rtl/rail_seq_pkg.sv
`timescale 1ns/1ps
package rail_seq_pkg;
  localparam int unsigned RAIL_COUNT = 4;
  localparam int unsigned CODE_W     = 2;
  localparam int unsigned UNIT_W     = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic [RAIL_COUNT-1:0] railClr;
    logic                  postClr;
  } seqStrb_t;

  // tick count that marks completion; one extra tick so the delay never
  // comes out short when the shared tick phase is arbitrary
  function automatic logic [UNIT_W-1:0] codeToTicks(input logic [CODE_W-1:0] code);
    case (code)
      2'd0:    return UNIT_W'(11);
      2'd1:    return UNIT_W'(51);
      2'd2:    return UNIT_W'(101);
      default: return UNIT_W'(501);
    endcase
  endfunction
endpackage

// File: rtl/rail_seq_dlycnt.sv
`timescale 1ns/1ps
module rail_seq_dlycnt
  import rail_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              tick,
  input  logic [UNIT_W-1:0] target,
  output logic              done
);
  logic [UNIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (tick && cnt < target)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt >= target);
endmodule

// File: rtl/rail_seq_dp.sv
`timescale 1ns/1ps
module rail_seq_dp
  import rail_seq_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 1000000,
  parameter int unsigned MR_CYCLES   = 500
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [RAIL_COUNT-1:0]        railOkAsync,
  input  logic                         mrAsync,
  input  logic [CODE_W*RAIL_COUNT-1:0] railDlyCfg,
  input  logic [CODE_W-1:0]            postDlyCfg,
  input  seqStrb_t                     strb,
  output logic [RAIL_COUNT-1:0]        railOkSync,
  output logic                         mrHeld,
  output logic [RAIL_COUNT-1:0]        railDone,
  output logic                         postDone
);
  localparam int unsigned SYNC_W = RAIL_COUNT + 1;
  localparam int unsigned TICK_W = $clog2(TICK_CYCLES + 1);
  localparam int unsigned MR_W   = $clog2(MR_CYCLES + 1);

  // two-flop synchronizers, manual reset in the top bit
  logic [SYNC_W-1:0] syncA, syncB;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= {mrAsync, railOkAsync};
      syncB <= syncA;
    end
  end
  assign railOkSync = syncB[RAIL_COUNT-1:0];

  // shared prescaler
  logic [TICK_W-1:0] tickCnt;
  logic              tickPulse;
  assign tickPulse = (tickCnt == TICK_W'(TICK_CYCLES - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          tickCnt <= '0;
    else if (tickPulse) tickCnt <= '0;
    else                tickCnt <= tickCnt + 1'b1;
  end

  // manual reset qualification: consecutive high cycles
  logic [MR_W-1:0] mrCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          mrCnt <= '0;
    else if (!syncB[RAIL_COUNT])        mrCnt <= '0;
    else if (mrCnt != MR_W'(MR_CYCLES)) mrCnt <= mrCnt + 1'b1;
  end
  assign mrHeld = (mrCnt == MR_W'(MR_CYCLES));

  for (genvar g = 0; g < RAIL_COUNT; g++) begin : gRail
    rail_seq_dlycnt railCnt_i (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (strb.railClr[g]),
      .tick   (tickPulse),
      .target (codeToTicks(railDlyCfg[CODE_W*g +: CODE_W])),
      .done   (railDone[g])
    );
  end

  rail_seq_dlycnt postCnt_i (
    .clk    (clk),
    .rstN   (rstN),
    .clr    (strb.postClr),
    .tick   (tickPulse),
    .target (codeToTicks(postDlyCfg)),
    .done   (postDone)
  );
endmodule

// File: rtl/rail_seq_ctrl.sv
`timescale 1ns/1ps
module rail_seq_ctrl
  import rail_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [RAIL_COUNT-1:0] railOkSync,
  input  logic                  mrHeld,
  input  logic [RAIL_COUNT-1:0] railDone,
  input  logic                  postDone,
  input  logic [RAIL_COUNT-1:0] faultSet,
  output seqStrb_t              strb,
  output logic [RAIL_COUNT-1:0] pgN,
  output logic                  rstOutN,
  output logic [RAIL_COUNT-1:0] faultFlags
);
  always_comb begin
    strb.railClr = ~railOkSync | {RAIL_COUNT{mrHeld}};
    strb.postClr = mrHeld | ~(&railOkSync) | ~(&railDone);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgN     <= '1;
      rstOutN <= 1'b0;
    end else begin
      pgN     <= ~railDone;
      rstOutN <= postDone & (&railDone) & ~mrHeld;
    end
  end

  for (genvar g = 0; g < RAIL_COUNT; g++) begin : gFault
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              faultFlags[g] <= 1'b0;
      else if (!railOkSync[g]) faultFlags[g] <= 1'b0;
      else if (faultSet[g])    faultFlags[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/rail_seq_top.sv
`timescale 1ns/1ps
module rail_seq_top
  import rail_seq_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 1000000,
  parameter int unsigned MR_CYCLES   = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] railOk,
  input  logic       mrIn,
  input  logic [7:0] railDlyCfg,
  input  logic [1:0] postDlyCfg,
  input  logic [3:0] faultSet,
  output logic [3:0] pgN,
  output logic       rstOutN,
  output logic [3:0] faultFlags
);
  logic [RAIL_COUNT-1:0] railOkSync;
  logic [RAIL_COUNT-1:0] railDone;
  logic                  mrHeld;
  logic                  postDone;
  seqStrb_t              strb;

  rail_seq_dp #(
    .TICK_CYCLES (TICK_CYCLES),
    .MR_CYCLES   (MR_CYCLES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .railOkAsync (railOk),
    .mrAsync     (mrIn),
    .railDlyCfg  (railDlyCfg),
    .postDlyCfg  (postDlyCfg),
    .strb        (strb),
    .railOkSync  (railOkSync),
    .mrHeld      (mrHeld),
    .railDone    (railDone),
    .postDone    (postDone)
  );

  rail_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .railOkSync (railOkSync),
    .mrHeld     (mrHeld),
    .railDone   (railDone),
    .postDone   (postDone),
    .faultSet   (faultSet),
    .strb       (strb),
    .pgN        (pgN),
    .rstOutN    (rstOutN),
    .faultFlags (faultFlags)
  );
endmodule

// File: rtl/rail_seq_chk.sv
`timescale 1ns/1ps
module rail_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] railOkSync,
  input logic       mrHeld,
  input logic [3:0] faultSet,
  input logic [3:0] pgN,
  input logic       rstOutN,
  input logic [3:0] faultFlags
);
  // R5: reset released only with every rail through its delay
  a_r5_rst_needs_all_good: assert property (@(posedge clk) disable iff (!rstN)
    rstOutN |-> (pgN == 4'h0));

  // R7: accepted manual reset forces every output
  a_r7_mr_forces_outputs: assert property (@(posedge clk) disable iff (!rstN)
    mrHeld |-> ##2 (!rstOutN && pgN == 4'hF));

  for (genvar g = 0; g < 4; g++) begin : gRail
    // R4: a dropped rail raises its good output
    a_r4_drop_raises_pg: assert property (@(posedge clk) disable iff (!rstN)
      !railOkSync[g] |-> ##2 pgN[g]);
    // R6: a dropped rail asserts the system reset
    a_r6_drop_asserts_rst: assert property (@(posedge clk) disable iff (!rstN)
      !railOkSync[g] |-> ##2 !rstOutN);
    // R9: a low rail clears its flag
    a_r9_fault_clears: assert property (@(posedge clk) disable iff (!rstN)
      !railOkSync[g] |=> !faultFlags[g]);
    // R9: a cleared flag rises only through a set pulse
    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (!faultFlags[g] && !faultSet[g]) |=> !faultFlags[g]);
  end
endmodule

bind rail_seq_top rail_seq_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .railOkSync (railOkSync),
  .mrHeld     (mrHeld),
  .faultSet   (faultSet),
  .pgN        (pgN),
  .rstOutN    (rstOutN),
  .faultFlags (faultFlags)
);

// File: tb/rail_seq_top_tb_top.sv
`timescale 1ns/1ps
module rail_seq_top_tb_top;
  localparam int unsigned TB_TICK = 4;
  localparam int unsigned TB_MR   = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] railOk;
  logic       mrIn;
  logic [7:0] railDlyCfg;
  logic [1:0] postDlyCfg;
  logic [3:0] faultSet;
  logic [3:0] pgN;
  logic       rstOutN;
  logic [3:0] faultFlags;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  rail_seq_top #(.TICK_CYCLES(TB_TICK), .MR_CYCLES(TB_MR)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .railOk     (railOk),
    .mrIn       (mrIn),
    .railDlyCfg (railDlyCfg),
    .postDlyCfg (postDlyCfg),
    .faultSet   (faultSet),
    .pgN        (pgN),
    .rstOutN    (rstOutN),
    .faultFlags (faultFlags)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; railOk = 4'h0; mrIn = 1'b0;
    railDlyCfg = 8'h00; postDlyCfg = 2'b00; faultSet = 4'h0;
    waitCyc(5);
    chk("R1 pgN in reset", pgN, 4'hF);
    chk("R1 rstOutN in reset", rstOutN, 1'b0);
    rstN = 1'b1;
    waitCyc(2);
    chk("R1 faultFlags after reset", faultFlags, 4'h0);
    chk("R1 pgN after reset", pgN, 4'hF);
  endtask

  task automatic testDefaultSeq();
    railOk = 4'hF;
    waitCyc(38);
    chk("R2 code 00 not yet done", pgN, 4'hF);
    waitCyc(12);
    chk("R2 code 00 done", pgN, 4'h0);
    chk("R5 reset held during post delay", rstOutN, 1'b0);
    waitCyc(30);
    chk("R5 post delay lower bound", rstOutN, 1'b0);
    waitCyc(30);
    chk("R5 reset released", rstOutN, 1'b1);
  endtask

  task automatic testPerRailCodes();
    railOk = 4'h0;
    waitCyc(10);
    railDlyCfg = 8'hE4;   // rail0 00, rail1 01, rail2 10, rail3 11
    railOk = 4'hF;
    waitCyc(50);
    chk("R3 only rail0 done", pgN, 4'hE);
    waitCyc(160);
    chk("R3 rail1 done (code 01)", pgN, 4'hC);
    waitCyc(200);
    chk("R3 rail2 done (code 10)", pgN, 4'h8);
    waitCyc(1580);
    chk("R2 rail3 code 11 not yet done", pgN, 4'h8);
    waitCyc(20);
    chk("R2 rail3 code 11 done", pgN, 4'h0);
    chk("R5 reset waits after last rail", rstOutN, 1'b0);
    waitCyc(100);
    chk("R5 reset released after long seq", rstOutN, 1'b1);
  endtask

  task automatic testDropAndGlitch();
    railDlyCfg = 8'h00;
    waitCyc(2);
    railOk = 4'b1011;
    waitCyc(5);
    chk("R4 dropped rail raises pg", pgN, 4'b0100);
    chk("R6 drop asserts reset", rstOutN, 1'b0);
    railOk = 4'hF;
    waitCyc(30);
    railOk = 4'b1011;
    waitCyc(3);
    railOk = 4'hF;
    waitCyc(38);
    chk("R4 glitch restarted count", pgN, 4'b0100);
    waitCyc(12);
    chk("R4 rail done after restart", pgN, 4'h0);
    waitCyc(60);
    chk("R6 sequence completes again", rstOutN, 1'b1);
  endtask

  task automatic testManualReset();
    mrIn = 1'b1;
    waitCyc(4);
    mrIn = 1'b0;
    waitCyc(10);
    chk("R7 short pulse ignored rst", rstOutN, 1'b1);
    chk("R7 short pulse ignored pg", pgN, 4'h0);
    mrIn = 1'b1;
    waitCyc(20);
    chk("R7 held mr forces pg", pgN, 4'hF);
    chk("R7 held mr forces rst", rstOutN, 1'b0);
    waitCyc(10);
    mrIn = 1'b0;
    waitCyc(38);
    chk("R8 pg still held after release", pgN, 4'hF);
    waitCyc(14);
    chk("R8 pg re-released", pgN, 4'h0);
    waitCyc(28);
    chk("R8 reset still in post delay", rstOutN, 1'b0);
    waitCyc(40);
    chk("R8 reset re-released", rstOutN, 1'b1);
  endtask

  task automatic testFaults();
    faultSet = 4'hF;
    waitCyc(1);
    faultSet = 4'h0;
    waitCyc(2);
    chk("R9 preset flags", faultFlags, 4'hF);
    railOk = 4'b0111;
    waitCyc(5);
    chk("R9 failed rail clears flag", faultFlags, 4'b0111);
    railOk = 4'hF;
    waitCyc(20);
    chk("R9 flag sticky after recovery", faultFlags, 4'b0111);
    railOk = 4'b1110;
    waitCyc(5);
    faultSet = 4'b0001;
    waitCyc(1);
    faultSet = 4'h0;
    waitCyc(2);
    chk("R9 clear wins over set", faultFlags, 4'b0110);
    railOk = 4'hF;
    waitCyc(5);
    faultSet = 4'b1001;
    waitCyc(1);
    faultSet = 4'h0;
    waitCyc(2);
    chk("R9 flags preset again", faultFlags, 4'hF);
  endtask

  initial begin
    testReset();
    testDefaultSeq();
    testPerRailCodes();
    testDropAndGlitch();
    testManualReset();
    testFaults();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule